// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns a bank of asynchronous external interrupt lines into request flags in the system clock domain. Eight maskable lines each pass through a synchroniser and an edge detector. Each line has its own enable bit and its own 2-bit mode field, which picks rising, falling or both edges. A recognised edge on an enabled line sets a sticky pending bit. That bit stays set until the matching clear strobe is pulsed.

One further line is non-maskable. It fires on every transition, whatever its polarity, and produces a one-cycle request pulse. Every line has a short blanking window: once a transition is taken, further transitions on the same line are ignored for a few cycles. After reset, the first samples are discarded, so a line that is already high at reset does not raise a request. Priority, vectoring and any handshake with a processor belong to the logic that consumes these outputs.

Top module: `xint_edge_bank`

## Requirements
- R1: While reset is asserted, pend_o is all zeros and nmi_req_o is 0.
- R2: A level change on an input that then stays stable shows its effect after the third rising clock edge following the change. After only two rising edges, pend_o and nmi_req_o still show no effect.
- R3: Mode field value 00 (edge_sel bits [2i+1:2i] for line i) selects rising edges: a 0-to-1 change sets pend_o[i], and a 1-to-0 change does not.
- R4: Mode value 01 selects falling edges: a 1-to-0 change sets pend_o[i], and a 0-to-1 change does not.
- R5: Mode value 10 selects both edges: either change sets pend_o[i].
- R6: Mode value 11 is reserved: no change on that line sets pend_o[i].
- R7: While enable[i] is 0, no change on line i sets pend_o[i].
- R8: A set pending bit holds until pend_clr[i] is high at a rising clock edge. After that edge the bit reads 0, and a pending bit never falls without a clear.
- R9: When a recognised edge and pend_clr[i] fall in the same cycle, pend_o[i] stays 1.
- R10: Every transition of nmi_in, rising or falling, gives a pulse on nmi_req_o that lasts exactly one cycle. The enable bits and mode fields have no effect on it.
- R11: After a transition is taken on a line, any transition that reaches the synchronised side of that line within the next 3 cycles is ignored. Two input transitions 4 or more cycles apart are both taken, and ones 2 or 3 cycles apart yield a single event.
- R12: An input already high while reset is asserted raises no request after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Asynchronous maskable interrupt lines |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt line |
| enable | input | NUM_IN | Per-line enable |
| edge_sel | input | 2*NUM_IN | Per-line mode: 00 rising, 01 falling, 10 both, 11 off |
| pend_clr | input | NUM_IN | Per-line clear strobe for the pending bits |
| pend_o | output | NUM_IN | Sticky pending flags |
| nmi_req_o | output | 1 | One-cycle non-maskable request pulse |

## Verification
Three registers lie between a line and its result: two synchroniser flops, then the pending or request register. The edge compare against the previous sample is combinational in between. The bench changes inputs on falling clock edges and samples on falling edges. It looks after the second rising edge, where nothing must have changed yet, and again after the third, where pend_o or the nmi_req_o pulse must be visible; for the non-maskable pulse it also looks after the fourth, where the pulse must be gone. The same-cycle clear test raises pend_clr during exactly the cycle that ends at that third edge. The blanking tests space the non-maskable transitions by whole cycles and count the request pulses after the line has settled.

// File: rtl/xint_pkg.sv
package xint_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_OFF  = 2'b11
   } edge_mode_t;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xint_edge_chan.sv
module xint_edge_chan
   import xint_pkg::*;
#(
   parameter int BLANK_CYCLES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s,
   input  logic       arm,
   input  edge_mode_t mode,
   output logic       hit
);
   localparam int CW = $clog2(BLANK_CYCLES + 1);

   logic          prev_q;
   logic [CW-1:0] cnt_q;
   logic          trans;

   assign trans = arm && (s != prev_q) && (cnt_q == '0);

   always_comb begin
      case (mode)
         EDGE_RISE: hit = trans & s;
         EDGE_FALL: hit = trans & ~s;
         EDGE_BOTH: hit = trans;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= s;
         if (trans)             cnt_q <= CW'(BLANK_CYCLES);
         else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/xint_edge_bank.sv
module xint_edge_bank
   import xint_pkg::*;
#(
   parameter int NUM_IN       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int BLANK_CYCLES = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_IN-1:0]     irq_in,
   input  logic                  nmi_in,
   input  logic [NUM_IN-1:0]     enable,
   input  logic [2*NUM_IN-1:0]   edge_sel,
   input  logic [NUM_IN-1:0]     pend_clr,
   output logic [NUM_IN-1:0]     pend_o,
   output logic                  nmi_req_o
);
   if (NUM_IN < 1) begin : g_bad_num
      $error("NUM_IN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BLANK_CYCLES < 1) begin : g_bad_blank
      $error("BLANK_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES:0] arm_q;
   logic                 armed;
   logic [NUM_IN-1:0]    s_sync;
   logic [NUM_IN-1:0]    hit;
   logic [NUM_IN-1:0]    pend_q;
   logic                 nmi_sync;
   logic                 nmi_hit;
   logic                 nmi_req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= '0;
      else        arm_q <= {arm_q[SYNC_STAGES-1:0], 1'b1};
   end
   assign armed = arm_q[SYNC_STAGES];

   for (genvar i = 0; i < NUM_IN; i++) begin : g_line
      xint_sync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (irq_in[i]),
         .q     (s_sync[i])
      );
      xint_edge_chan #(.BLANK_CYCLES(BLANK_CYCLES)) chan_i (
         .clk   (clk),
         .rst_n (rst_n),
         .s     (s_sync[i]),
         .arm   (armed),
         .mode  (edge_mode_t'(edge_sel[2*i +: 2])),
         .hit   (hit[i])
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= (hit[i] & enable[i]) | (pend_q[i] & ~pend_clr[i]);
      end
   end

   xint_sync #(.STAGES(SYNC_STAGES)) nmi_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nmi_in),
      .q     (nmi_sync)
   );
   xint_edge_chan #(.BLANK_CYCLES(BLANK_CYCLES)) nmi_chan_i (
      .clk   (clk),
      .rst_n (rst_n),
      .s     (nmi_sync),
      .arm   (armed),
      .mode  (EDGE_BOTH),
      .hit   (nmi_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_req_q <= 1'b0;
      else        nmi_req_q <= nmi_hit;
   end

   assign pend_o    = pend_q;
   assign nmi_req_o = nmi_req_q;
endmodule

// File: rtl/xint_chk.sv
module xint_chk #(
   parameter int NUM_IN       = 8,
   parameter int BLANK_CYCLES = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_IN-1:0]   enable,
   input logic [2*NUM_IN-1:0] edge_sel,
   input logic [NUM_IN-1:0]   pend_clr,
   input logic [NUM_IN-1:0]   pend_o,
   input logic                nmi_req_o
);
   localparam int GW = $clog2(BLANK_CYCLES + 1);

   logic [NUM_IN-1:0] reserved;
   logic [GW-1:0]     gap_q;

   always_comb begin
      for (int i = 0; i < NUM_IN; i++)
         reserved[i] = (edge_sel[2*i +: 2] == 2'b11);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gap_q <= GW'(BLANK_CYCLES);
      else if (nmi_req_o)                 gap_q <= '0;
      else if (gap_q != GW'(BLANK_CYCLES)) gap_q <= gap_q + GW'(1);
   end

   assert_no_fall_without_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pend_o & $past(pend_o) & ~$past(pend_clr)) == '0));

   assert_disabled_never_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_o & ~$past(pend_o) & ~$past(enable)) == '0));

   assert_reserved_never_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_o & ~$past(pend_o) & $past(reserved)) == '0));

   assert_nmi_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req_o |=> !nmi_req_o);

   assert_nmi_blank_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req_o |-> (gap_q == GW'(BLANK_CYCLES)));
endmodule

bind xint_edge_bank xint_chk #(
   .NUM_IN       (NUM_IN),
   .BLANK_CYCLES (BLANK_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .edge_sel  (edge_sel),
   .pend_clr  (pend_clr),
   .pend_o    (pend_o),
   .nmi_req_o (nmi_req_o)
);

// File: tb/xint_edge_bank_tb.sv
module xint_edge_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [N-1:0]   irq_in;
   logic           nmi_in;
   logic [N-1:0]   enable;
   logic [2*N-1:0] edge_sel;
   logic [N-1:0]   pend_clr;
   logic [N-1:0]   pend_o;
   logic           nmi_req_o;

   int total = 0;
   int bad = 0;
   int nmi_cnt = 0;
   bit nmi_prev = 1'b0;
   bit nmi_wide = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xint_edge_bank #(.NUM_IN(N)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .nmi_in    (nmi_in),
      .enable    (enable),
      .edge_sel  (edge_sel),
      .pend_clr  (pend_clr),
      .pend_o    (pend_o),
      .nmi_req_o (nmi_req_o)
   );

   // fields: ch[7:5] mode[4:3] en[2] start[1] expect[0]
   localparam logic [7:0] VECS [11] = '{
      {3'd0, 2'b00, 1'b1, 1'b0, 1'b1},
      {3'd0, 2'b00, 1'b1, 1'b1, 1'b0},
      {3'd1, 2'b01, 1'b1, 1'b1, 1'b1},
      {3'd1, 2'b01, 1'b1, 1'b0, 1'b0},
      {3'd2, 2'b10, 1'b1, 1'b0, 1'b1},
      {3'd2, 2'b10, 1'b1, 1'b1, 1'b1},
      {3'd3, 2'b11, 1'b1, 1'b0, 1'b0},
      {3'd3, 2'b11, 1'b1, 1'b1, 1'b0},
      {3'd4, 2'b10, 1'b0, 1'b0, 1'b0},
      {3'd7, 2'b00, 1'b1, 1'b0, 1'b1},
      {3'd5, 2'b01, 1'b0, 1'b1, 1'b0}
   };

   always @(negedge clk) begin
      if (nmi_req_o) nmi_cnt++;
      if (nmi_req_o && nmi_prev) nmi_wide = 1'b1;
      nmi_prev = nmi_req_o;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string vec_tag(input logic en, input logic [1:0] mode);
      if (!en) return "R7 disabled line";
      case (mode)
         2'b00:   return "R3 rising mode";
         2'b01:   return "R4 falling mode";
         2'b10:   return "R5 both mode";
         default: return "R6 reserved mode";
      endcase
   endfunction

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      pend_clr = '1;
      @(negedge clk);
      pend_clr = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      irq_in   = '1;
      nmi_in   = 1'b1;
      enable   = '1;
      edge_sel = {N{2'b10}};
      pend_clr = '0;
      cycles(5);
      chk("R1 pend in reset", 32'(pend_o), 0);
      chk("R1 nmi in reset", 32'(nmi_req_o), 0);
      rst_n = 1'b1;
      cycles(10);
      chk("R12 pend after reset with high inputs", 32'(pend_o), 0);
      chk("R12 nmi pulses after reset", nmi_cnt, 0);

      // vector table
      for (int v = 0; v < 11; v++) begin
         automatic int         ch   = int'(VECS[v][7:5]);
         automatic logic [1:0] mode = VECS[v][4:3];
         automatic logic       en   = VECS[v][2];
         automatic logic       st   = VECS[v][1];
         automatic logic       ex   = VECS[v][0];
         edge_sel[2*ch +: 2] = mode;
         enable = '0;
         enable[ch] = en;
         irq_in[ch] = st;
         cycles(8);
         clear_all();
         cycles(1);
         chk("R8 cleared before stimulus", 32'(pend_o), 0);
         irq_in[ch] = ~st;
         @(posedge clk);
         @(posedge clk);
         @(negedge clk);
         chk("R2 no effect after two edges", 32'(pend_o), 0);
         @(posedge clk);
         @(negedge clk);
         chk(vec_tag(en, mode), 32'(pend_o), 32'(ex) << ch);
      end

      // sticky and clear on line 0, rising mode
      edge_sel[1:0] = 2'b00;
      enable = 8'h01;
      irq_in[0] = 1'b0;
      cycles(8);
      clear_all();
      irq_in[0] = 1'b1;
      cycles(6);
      chk("R3 line0 rising sets", 32'(pend_o[0]), 1);
      cycles(10);
      chk("R8 pending holds", 32'(pend_o[0]), 1);
      clear_all();
      chk("R8 clear strobe resets", 32'(pend_o[0]), 0);

      // clear coinciding with set, both mode
      edge_sel[1:0] = 2'b10;
      irq_in[0] = 1'b0;
      cycles(8);
      chk("R5 line0 falling sets", 32'(pend_o[0]), 1);
      irq_in[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      pend_clr[0] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pend_clr[0] = 1'b0;
      chk("R9 set beats clear", 32'(pend_o[0]), 1);
      cycles(3);
      chk("R9 stays set afterwards", 32'(pend_o[0]), 1);

      // non-maskable line, masks all off
      enable = '0;
      edge_sel = '1;
      begin
         automatic int c0 = nmi_cnt;
         nmi_in = 1'b0;
         @(posedge clk);
         @(posedge clk);
         @(negedge clk);
         chk("R2 nmi not yet", 32'(nmi_req_o), 0);
         @(posedge clk);
         @(negedge clk);
         chk("R10 nmi on falling", 32'(nmi_req_o), 1);
         @(posedge clk);
         @(negedge clk);
         chk("R10 nmi pulse ends", 32'(nmi_req_o), 0);
         cycles(8);
         nmi_in = 1'b1;
         cycles(8);
         chk("R10 nmi on rising", nmi_cnt - c0, 2);
      end

      // blanking window
      for (int d = 2; d <= 5; d++) begin
         automatic int c1 = nmi_cnt;
         nmi_in = ~nmi_in;
         cycles(d);
         nmi_in = ~nmi_in;
         cycles(10);
         chk("R11 blanking spacing", nmi_cnt - c1, (d >= 4) ? 2 : 1);
      end
      chk("R10 nmi never wider than one cycle", 32'(nmi_wide), 0);
      chk("R7 no pending from nmi activity", 32'(pend_o), 32'h01);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule